// File: doc/BRIEF.md
# Three-Wire Host Control Port

This block is the host-facing control port of a baseband voice/data chip. A host controller drives three wires: a serial clock, a serial data line and a direction/strobe line. While the strobe is high, the host shifts a ten-bit write frame into the port, most significant bit first. The frame holds a two-bit register address followed by eight data bits. The port stores the frame when the strobe falls. It applies the frame only if exactly ten serial clocks arrived while the strobe was high. The port decodes four internal registers into plain control outputs: power-domain enables, path-switch bits, feature enables and volume codes. The analog volume stages and switches themselves are outside this block.

While the strobe is low, the port becomes a read port. It drives the most recently received demodulator byte back to the host with no address bits, most significant bit first. The demodulator side delivers bytes over a valid/ready stream into a one-byte buffer. The port accepts a byte only when the buffer is empty. The buffer empties once the host has clocked out all eight bits, so the producer must hold a byte until the host has read the previous one.

All three serial wires are sampled in the core clock domain through a synchronizer of `SYNC_STAGES` flops. Every serial event therefore acts `SYNC_STAGES`+1 core clock edges after the first edge that samples it.

Top module: `sctl_port`

## Requirements
- R1: After reset the outputs decode the following register values. Control register A is 8'hEC, which gives power mode 0. The volume pair register is 8'h88, which gives mic and modulator volume code 8. The earpiece register holds select 0 and volume 4. Control register B is 8'hD8, which gives demodulator volume code 8. test_mode is 0, the receive buffer is empty, and ser_dout_oe is 0.
- R2: While ser_dir is high, each ser_clk rise shifts ser_din into a frame. The frame is {addr[1:0], data[7:0]}, sent MSB first. The fall of ser_dir applies the frame to the addressed register. The decoded outputs change SYNC_STAGES+1 core edges after the first edge that samples ser_dir low.
- R3: A frame that received any number of ser_clk rises other than 10 between the ser_dir rise and the following fall leaves every register unchanged.
- R4: Address 0 holds control register A. From bit 7 down to bit 0 it drives flag_sel, the power bits P1 and P0, frame_hunt_off, scr_bypass, tx_msk_off, tx_path_sel and rx_path_sel.
- R5: Address 1 holds the volume pair. Bits 7:4 are vol_mod and bits 3:0 are vol_mic.
- R6: At address 2, bit 3 is ear_sel and bits 2:0 are vol_ear. test_mode becomes 1 when a write to address 2 has any of bits 7:4 at 0. It returns to 0 when a write to address 2 has bits 7:4 all at 1.
- R7: Address 3 holds control register B. Bit 7 is comp_on, bit 6 is emph_on, bit 5 is frame_pat_sel, bit 4 is carrier_sel, and bits 3:0 are vol_demod.
- R8: The power mode is 3 minus {P1,P0}. Mode 0 enables nothing. Mode 1 enables only pwr_osc_en. Mode 2 adds pwr_rxmsk_en. Mode 3 also enables pwr_voice_en.
- R9: rx_ready is high exactly while the receive buffer is empty. A byte is taken on a clock edge where rx_valid and rx_ready are both high. byte_avail goes high on that same edge. While the buffer is full, rx_data is ignored.
- R10: ser_dout_oe follows an inverted ser_dir, with a lag of SYNC_STAGES+1 edges. While ser_dir is low and the buffer is full, ser_dout presents buffer bit 7 first, and each ser_clk rise advances it one bit toward bit 0. The eighth rise empties the buffer. ser_dout is 0 whenever the buffer is empty.
- R11: A rise of ser_dir restarts an unfinished read at bit 7 and keeps the byte in the buffer.
- R12: Shifting ser_clk bits never changes any decoded output before the commit on the ser_dir fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Host serial clock |
| ser_dir | input | 1 | Host direction/strobe, high = write frame, low = read |
| ser_din | input | 1 | Host serial write data |
| ser_dout | output | 1 | Serial read data |
| ser_dout_oe | output | 1 | Read data drive enable |
| rx_valid | input | 1 | Demodulator byte valid |
| rx_ready | output | 1 | Receive buffer empty, byte accepted |
| rx_data | input | 8 | Demodulator byte |
| byte_avail | output | 1 | Receive buffer holds an unread byte |
| pwr_osc_en | output | 1 | Oscillator domain enable |
| pwr_rxmsk_en | output | 1 | Data receive domain enable |
| pwr_voice_en | output | 1 | Voice and transmit domain enable |
| flag_sel | output | 1 | Status pin source select |
| frame_hunt_off | output | 1 | Frame search disabled |
| scr_bypass | output | 1 | Spectrum inverter bypassed |
| tx_msk_off | output | 1 | Data transmit clock off |
| tx_path_sel | output | 1 | Transmit path switch |
| rx_path_sel | output | 1 | Receive path switch |
| ear_sel | output | 1 | Earpiece switch |
| carrier_sel | output | 1 | Inversion carrier select |
| frame_pat_sel | output | 1 | Frame pattern select |
| emph_on | output | 1 | Emphasis enable |
| comp_on | output | 1 | Compander enable |
| vol_mic | output | 4 | Microphone volume code |
| vol_mod | output | 4 | Modulator volume code |
| vol_demod | output | 4 | Demodulator volume code |
| vol_ear | output | 3 | Earpiece volume code |
| test_mode | output | 1 | Test mode flag |

## Verification
The bench builds the port with the default SYNC_STAGES of 2. Each half of the serial clock lasts four core cycles, so the window in which a serial edge is seen is only one cycle shorter than a serial pulse. Holding latency at three edges brings exact-cycle checks of every commit, read shift and buffer release within reach. The bench also sends truncated and overlong frames, writes that set and clear the test flag, and producer pushes against a full buffer.

// File: rtl/sctl_pkg.sv
`timescale 1ns/1ps
package sctl_pkg;
  localparam int ADDR_W    = 2;
  localparam int DATA_W    = 8;
  localparam int FRAME_LEN = ADDR_W + DATA_W;
  localparam int EAR_W     = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTL_A = 2'd0,
    REG_VOL_P = 2'd1,
    REG_EAR   = 2'd2,
    REG_CTL_B = 2'd3
  } reg_addr_e;

  localparam logic [DATA_W-1:0] CTL_A_RST = 8'hEC;
  localparam logic [DATA_W-1:0] VOL_P_RST = 8'h88;
  localparam logic [EAR_W-1:0]  EAR_RST   = 4'h4;
  localparam logic [DATA_W-1:0] CTL_B_RST = 8'hD8;

  typedef struct packed {
    logic osc;
    logic rxmsk;
    logic voice;
  } pwr_t;

  function automatic pwr_t pwr_decode(input logic [1:0] pbits);
    logic [1:0] mode;
    pwr_t p;
    mode    = 2'd3 - pbits;
    p.osc   = (mode != 2'd0);
    p.rxmsk = (mode >= 2'd2);
    p.voice = (mode == 2'd3);
    return p;
  endfunction
endpackage

// File: rtl/sctl_sync.sv
`timescale 1ns/1ps
module sctl_sync #(
  parameter int           N       = 3,
  parameter int           STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q,
  output logic [N-1:0] q_prev
);
  logic [STAGES-1:0][N-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q  <= {STAGES{RST_VAL}};
      q_prev <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      q_prev <= stg_q[STAGES-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/sctl_wr.sv
`timescale 1ns/1ps
module sctl_wr
  import sctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              dir_rise,
  input  logic              dir_fall,
  input  logic              dir_hi,
  input  logic              din,
  output logic              cmt_vld,
  output logic [ADDR_W-1:0] cmt_addr,
  output logic [DATA_W-1:0] cmt_data
);
  localparam int CNT_W = $clog2(FRAME_LEN + 2);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_LEN + 1);

  logic [FRAME_LEN-1:0] sh_q;
  logic [CNT_W-1:0]     cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (dir_rise) begin
      cnt_q <= '0;
    end else if (sclk_rise && dir_hi) begin
      sh_q <= {sh_q[FRAME_LEN-2:0], din};
      if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cmt_vld  = dir_fall && (cnt_q == CNT_W'(FRAME_LEN));
  assign cmt_addr = sh_q[FRAME_LEN-1 -: ADDR_W];
  assign cmt_data = sh_q[DATA_W-1:0];

  // R3: the bit counter saturates one past a full frame
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_SAT);
  // R2: a new write window starts a fresh count
  a_r2_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
    dir_rise |=> (cnt_q == '0));
endmodule

// File: rtl/sctl_regs.sv
`timescale 1ns/1ps
module sctl_regs
  import sctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmt_vld,
  input  logic [ADDR_W-1:0] cmt_addr,
  input  logic [DATA_W-1:0] cmt_data,
  output logic [DATA_W-1:0] ctl_a,
  output logic [DATA_W-1:0] vol_p,
  output logic [EAR_W-1:0]  ear,
  output logic [DATA_W-1:0] ctl_b,
  output logic              test_flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_a     <= CTL_A_RST;
      vol_p     <= VOL_P_RST;
      ear       <= EAR_RST;
      ctl_b     <= CTL_B_RST;
      test_flag <= 1'b0;
    end else if (cmt_vld) begin
      unique case (reg_addr_e'(cmt_addr))
        REG_CTL_A: ctl_a <= cmt_data;
        REG_VOL_P: vol_p <= cmt_data;
        REG_EAR: begin
          ear       <= cmt_data[EAR_W-1:0];
          test_flag <= ~&cmt_data[DATA_W-1:EAR_W];
        end
        REG_CTL_B: ctl_b <= cmt_data;
        default: ;
      endcase
    end
  end

  // R12: register contents move only on a commit
  a_r12_hold_regs: assert property (@(posedge clk) disable iff (!rst_n)
    !cmt_vld |=> $stable({ctl_a, vol_p, ear, ctl_b, test_flag}));
  // R6: the test flag rises only from a commit to address 2
  a_r6_test_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(test_flag) |-> $past(cmt_vld && (cmt_addr == REG_EAR)));
endmodule

// File: rtl/sctl_rd.sv
`timescale 1ns/1ps
module sctl_rd
  import sctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              dir_rise,
  input  logic              dir_hi,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  output logic              byte_avail,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

  logic [DATA_W-1:0] byte_q;
  logic [IDX_W-1:0]  idx_q;
  logic              full_q;
  logic              oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      idx_q  <= '0;
      full_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      oe_q <= ~dir_hi;
      if (!full_q) begin
        if (rx_valid) begin
          byte_q <= rx_data;
          full_q <= 1'b1;
          idx_q  <= '0;
        end
      end else if (dir_rise) begin
        idx_q <= '0;
      end else if (sclk_rise && !dir_hi) begin
        if (idx_q == IDX_LAST) begin
          full_q <= 1'b0;
          idx_q  <= '0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign rx_ready   = ~full_q;
  assign byte_avail = full_q;
  assign sdo        = full_q ? byte_q[IDX_LAST - idx_q] : 1'b0;
  assign sdo_oe     = oe_q;

  // R9: a held byte is never overwritten
  a_r9_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |=> $stable(byte_q));
  // R10: the buffer empties only through a read clock with the strobe low
  a_r10_pop_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full_q) |-> $past(sclk_rise && !dir_hi));
  // R11: a strobe rise rewinds the read position
  a_r11_restart_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_rise && full_q) |=> (idx_q == '0));
endmodule

// File: rtl/sctl_port.sv
`timescale 1ns/1ps
module sctl_port
  import sctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_clk,
  input  logic       ser_dir,
  input  logic       ser_din,
  output logic       ser_dout,
  output logic       ser_dout_oe,
  input  logic       rx_valid,
  output logic       rx_ready,
  input  logic [7:0] rx_data,
  output logic       byte_avail,
  output logic       pwr_osc_en,
  output logic       pwr_rxmsk_en,
  output logic       pwr_voice_en,
  output logic       flag_sel,
  output logic       frame_hunt_off,
  output logic       scr_bypass,
  output logic       tx_msk_off,
  output logic       tx_path_sel,
  output logic       rx_path_sel,
  output logic       ear_sel,
  output logic       carrier_sel,
  output logic       frame_pat_sel,
  output logic       emph_on,
  output logic       comp_on,
  output logic [3:0] vol_mic,
  output logic [3:0] vol_mod,
  output logic [3:0] vol_demod,
  output logic [2:0] vol_ear,
  output logic       test_mode
);
  localparam int B_CLK = 0;
  localparam int B_DIR = 1;
  localparam int B_DIN = 2;

  logic [2:0]        s_q, s_prev;
  logic              sclk_rise, dir_rise, dir_fall;
  logic              cmt_vld;
  logic [ADDR_W-1:0] cmt_addr;
  logic [DATA_W-1:0] cmt_data;
  logic [DATA_W-1:0] ctl_a, vol_p, ctl_b;
  logic [EAR_W-1:0]  ear;
  pwr_t              pwr;

  sctl_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({ser_din, ser_dir, ser_clk}),
    .q(s_q), .q_prev(s_prev));

  assign sclk_rise = s_q[B_CLK] & ~s_prev[B_CLK];
  assign dir_rise  = s_q[B_DIR] & ~s_prev[B_DIR];
  assign dir_fall  = ~s_q[B_DIR] & s_prev[B_DIR];

  sctl_wr u_wr (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .dir_rise(dir_rise),
    .dir_fall(dir_fall), .dir_hi(s_q[B_DIR]), .din(s_q[B_DIN]),
    .cmt_vld(cmt_vld), .cmt_addr(cmt_addr), .cmt_data(cmt_data));

  sctl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cmt_vld(cmt_vld), .cmt_addr(cmt_addr),
    .cmt_data(cmt_data), .ctl_a(ctl_a), .vol_p(vol_p), .ear(ear),
    .ctl_b(ctl_b), .test_flag(test_mode));

  sctl_rd u_rd (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .dir_rise(dir_rise),
    .dir_hi(s_q[B_DIR]), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .byte_avail(byte_avail), .sdo(ser_dout),
    .sdo_oe(ser_dout_oe));

  assign pwr            = pwr_decode(ctl_a[6:5]);
  assign pwr_osc_en     = pwr.osc;
  assign pwr_rxmsk_en   = pwr.rxmsk;
  assign pwr_voice_en   = pwr.voice;
  assign flag_sel       = ctl_a[7];
  assign frame_hunt_off = ctl_a[4];
  assign scr_bypass     = ctl_a[3];
  assign tx_msk_off     = ctl_a[2];
  assign tx_path_sel    = ctl_a[1];
  assign rx_path_sel    = ctl_a[0];
  assign vol_mod        = vol_p[7:4];
  assign vol_mic        = vol_p[3:0];
  assign ear_sel        = ear[3];
  assign vol_ear        = ear[2:0];
  assign comp_on        = ctl_b[7];
  assign emph_on        = ctl_b[6];
  assign frame_pat_sel  = ctl_b[5];
  assign carrier_sel    = ctl_b[4];
  assign vol_demod      = ctl_b[3:0];

  // R8: voice power never without the receive and oscillator domains
  a_r8_pwr_nest: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_voice_en |-> pwr_rxmsk_en) and (pwr_rxmsk_en |-> pwr_osc_en));
endmodule

// File: tb/sctl_port_tb_top.sv
`timescale 1ns/1ps
module sctl_port_tb_top;
  localparam int SYNC = 2;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dir = 1'b1, ser_din = 1'b0;
  logic ser_dout, ser_dout_oe;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic rx_ready, byte_avail;
  logic pwr_osc_en, pwr_rxmsk_en, pwr_voice_en, flag_sel, frame_hunt_off;
  logic scr_bypass, tx_msk_off, tx_path_sel, rx_path_sel, ear_sel;
  logic carrier_sel, frame_pat_sel, emph_on, comp_on, test_mode;
  logic [3:0] vol_mic, vol_mod, vol_demod;
  logic [2:0] vol_ear;

  always #2 clk = ~clk;

  sctl_port #(.SYNC_STAGES(SYNC)) dut_i (.*);

  int n_cmp = 0, n_bad = 0;
  bit live = 0, done = 0;

  // reference state
  logic [7:0] m_ca = 8'hEC, m_vp = 8'h88, m_cb = 8'hD8;
  logic [3:0] m_ear = 4'h4;
  bit m_test = 0, m_full = 0, m_oe = 0, m_dir = 1;
  logic [7:0] m_byte = 0;
  logic [9:0] m_sh = 0;
  int m_idx = 0, m_cnt = 0;

  task automatic chk(input string tag, input string nm, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic chk_all();
    int mode;
    mode = 3 - int'(m_ca[6:5]);
    chk("R8", "pwr_osc_en", pwr_osc_en, mode >= 1);
    chk("R8", "pwr_rxmsk_en", pwr_rxmsk_en, mode >= 2);
    chk("R8", "pwr_voice_en", pwr_voice_en, mode == 3);
    chk("R4", "flag_sel", flag_sel, m_ca[7]);
    chk("R4", "frame_hunt_off", frame_hunt_off, m_ca[4]);
    chk("R4", "scr_bypass", scr_bypass, m_ca[3]);
    chk("R4", "tx_msk_off", tx_msk_off, m_ca[2]);
    chk("R4", "tx_path_sel", tx_path_sel, m_ca[1]);
    chk("R4", "rx_path_sel", rx_path_sel, m_ca[0]);
    chk("R5", "vol_mod", vol_mod, m_vp[7:4]);
    chk("R5", "vol_mic", vol_mic, m_vp[3:0]);
    chk("R6", "ear_sel", ear_sel, m_ear[3]);
    chk("R6", "vol_ear", vol_ear, m_ear[2:0]);
    chk("R6", "test_mode", test_mode, m_test);
    chk("R7", "comp_on", comp_on, m_cb[7]);
    chk("R7", "emph_on", emph_on, m_cb[6]);
    chk("R7", "frame_pat_sel", frame_pat_sel, m_cb[5]);
    chk("R7", "carrier_sel", carrier_sel, m_cb[4]);
    chk("R7", "vol_demod", vol_demod, m_cb[3:0]);
    chk("R9", "rx_ready", rx_ready, !m_full);
    chk("R9", "byte_avail", byte_avail, m_full);
    chk("R10", "ser_dout_oe", ser_dout_oe, m_oe);
    chk("R10", "ser_dout", ser_dout, m_full ? m_byte[7 - m_idx] : 0);
  endtask

  always @(posedge clk) begin
    #1;
    if (live) chk_all();
  end

  task automatic commit(input logic [9:0] f);
    case (f[9:8])
      2'd0: m_ca = f[7:0];
      2'd1: m_vp = f[7:0];
      2'd2: begin m_ear = f[3:0]; m_test = (f[7:4] != 4'hF); end
      default: m_cb = f[7:0];
    endcase
  endtask

  task automatic set_dir(input bit v);
    if (v == m_dir) return;
    @(negedge clk) ser_dir = v;
    repeat (SYNC + 1) @(posedge clk);
    if (v) begin m_cnt = 0; m_idx = 0; m_oe = 0; end
    else begin m_oe = 1; if (m_cnt == 10) commit(m_sh); end
    m_dir = v;
    repeat (2) @(posedge clk);
  endtask

  task automatic pulse(input bit b);
    @(negedge clk) ser_din = b;
    repeat (HALF) @(posedge clk);
    @(negedge clk) ser_clk = 1'b1;
    repeat (SYNC + 1) @(posedge clk);
    if (m_dir) begin
      m_sh = {m_sh[8:0], b};
      if (m_cnt < 11) m_cnt++;
    end else if (m_full) begin
      m_idx++;
      if (m_idx == 8) begin m_full = 0; m_idx = 0; end
    end
    repeat (HALF - SYNC - 1) @(posedge clk);
    @(negedge clk) ser_clk = 1'b0;
    repeat (HALF) @(posedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input int n);
    logic [9:0] f;
    f = {a, d};
    set_dir(1);
    for (int i = 0; i < n; i++) pulse(i < 10 ? f[9 - i] : 1'b0);
    set_dir(0);
    set_dir(1);
  endtask

  task automatic push(input logic [7:0] d, input int hold);
    @(negedge clk) begin rx_valid = 1'b1; rx_data = d; end
    repeat (hold) begin
      @(posedge clk);
      if (!m_full) begin m_full = 1; m_byte = d; m_idx = 0; end
    end
    @(negedge clk) rx_valid = 1'b0;
  endtask

  task automatic rd(input int n);
    set_dir(0);
    for (int i = 0; i < n; i++) pulse(1'b1);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    // R1: reset state
    chk("R1", "vol_mic", vol_mic, 8);
    chk("R1", "vol_demod", vol_demod, 8);
    chk("R1", "vol_ear", vol_ear, 4);
    chk("R1", "ear_sel", ear_sel, 0);
    chk("R1", "pwr_osc_en", pwr_osc_en, 0);
    chk("R1", "test_mode", test_mode, 0);
    chk("R1", "ser_dout_oe", ser_dout_oe, 0);
    chk("R1", "rx_ready", rx_ready, 1);
    live = 1;

    // R2 R4 R8: control register A and each power mode
    wr(2'd0, 8'h13, 10);
    chk("R2", "pwr_voice_en after commit", pwr_voice_en, 1);
    wr(2'd0, 8'h53, 10);
    wr(2'd0, 8'h3A, 10);
    wr(2'd0, 8'h85, 10);
    // R5 R7
    wr(2'd1, 8'h5A, 10);
    wr(2'd3, 8'h2C, 10);
    chk("R7", "vol_demod", vol_demod, 12);
    // R6: test flag set and cleared
    wr(2'd2, 8'hF3, 10);
    wr(2'd2, 8'h7E, 10);
    chk("R6", "test_mode set", test_mode, 1);
    wr(2'd2, 8'hFD, 10);
    chk("R6", "test_mode cleared", test_mode, 0);
    // R3: short and long frames are discarded
    wr(2'd1, 8'h00, 9);
    wr(2'd3, 8'h00, 11);
    wr(2'd2, 8'h05, 0);
    chk("R3", "vol_mic kept", vol_mic, 4'hA);
    chk("R3", "comp_on kept", comp_on, 0);
    // R12: a frame in flight leaves outputs alone (per-clock compare)
    set_dir(1);
    for (int i = 0; i < 6; i++) pulse(1'b0);
    chk("R12", "vol_mod mid-frame", vol_mod, 5);
    set_dir(0);
    set_dir(1);

    // R9 R10: stream in and read out
    push(8'hA5, 1);
    push(8'h11, 3);
    rd(8);
    chk("R10", "empty after read", byte_avail, 0);
    set_dir(1);
    // R11: aborted read restarts at MSB
    push(8'h3C, 1);
    rd(3);
    set_dir(1);
    chk("R11", "byte kept", byte_avail, 1);
    rd(8);
    set_dir(1);
    push(8'hC3, 2);
    rd(8);
    set_dir(1);
    wr(2'd0, 8'h62, 10);

    repeat (4) @(posedge clk);
    live = 0;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule